// File: doc/BRIEF.md
# Priority-Indexed Interrupt Event Controller

This block gathers four event sources (transmit, receive, power-up, power-down) into one interrupt line. Each source has a sticky raw flag. A mask selects which flags count, and the masked status is the AND of the two. Software can force any flag on or off by writing ones to a set register or a clear register.

An index register names the lowest-numbered pending event that is not masked. A CPU read of this register acknowledges that event and clears it, so reading it over and over drains the pending events in priority order. A second read port, used by a debugger, can read every register with no side effect. The single interrupt output is registered and follows the masked status.

Register word addresses on both ports: 0 index, 1 mask, 2 raw status, 3 masked status, 4 set, 5 clear, 6 event mode. Event bit positions: 0 transmit, 1 receive, 2 power-up, 3 power-down.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A read of address 0 returns the number n of the lowest set bit of (raw AND mask) in bits 7:0. It returns 0xFF when no unmasked event is pending. Bit n of the status is reported as index n, and index 0 has the highest priority.
- R2: A CPU read of address 0 that reports an event clears that event's raw bit, and so its masked bit. The next read reports the next pending event, or 0xFF. A read that returns 0xFF clears nothing.
- R3: Debug-port reads of any address, including address 0, never change the raw status and never advance the index.
- R4: A mask bit of 1 enables the event. Address 3 reads raw AND mask.
- R5: Writing a 1 to a bit of address 4 sets that raw bit. The other raw bits are left as they are.
- R6: Writing a 1 to a bit of address 5 clears that raw bit, even when that event is masked.
- R7: Only bits 3:0 of the mask, raw and masked registers exist. Their upper bits read 0, and writes to those upper bits are ignored. Unmapped addresses read 0.
- R8: Address 6 (event mode) reads 1 and ignores writes.
- R9: irq_o is 1 exactly one cycle after any masked status bit is 1.
- R10: A pulse on hw_evt sets the matching raw bit. If that pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R11: Writing zero to address 4 or address 5 changes nothing. After reset the mask and raw status are 0 and irq_o is 0. The event mode is 1.
- R12: Read data and its valid strobe (cpu_rvalid or dbg_rvalid) appear in the cycle after the request. The strobe is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_evt | input | 4 | One-cycle event pulses from the sources |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 4 | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, registered |
| cpu_rvalid | output | 1 | CPU read data valid |
| dbg_req | input | 1 | Debug read request |
| dbg_addr | input | 4 | Debug word address |
| dbg_rdata | output | 32 | Debug read data, registered |
| dbg_rvalid | output | 1 | Debug read data valid |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
Every cycle, the assertions check the following: an acknowledging index read removes exactly one pending flag; a debug read leaves the raw status unchanged; a hardware pulse always lands in the raw status even when a clear write hits the same bit; irq_o tracks the masked status one cycle later; and an empty index reads 0xFF. The bench scenarios cover the rest: priority order while the index drains, masking with respect to the index and the masked view, upper bits and unmapped addresses reading zero, writes of zero and writes to the event mode being ignored, and the values after reset.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int AD_INDEX  = 0;
  localparam int AD_MASK   = 1;
  localparam int AD_RAW    = 2;
  localparam int AD_MASKED = 3;
  localparam int AD_SET    = 4;
  localparam int AD_CLR    = 5;
  localparam int AD_MODE   = 6;
endpackage

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
  parameter int NUM_EVT = 4,
  parameter int IDX_W   = 8
) (
  input  logic [NUM_EVT-1:0] vec_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  always_comb begin
    idx_o = IDX_NONE;
    any_o = 1'b0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] hw_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic [NUM_EVT-1:0] ack_i,
  output logic [NUM_EVT-1:0] raw_o
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        raw_o[g] <= 1'b0;
      else if (set_i[g] || hw_i[g])
        raw_o[g] <= 1'b1;
      else if (clr_i[g] || ack_i[g])
        raw_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_read_mux.sv
module evt_read_mux
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int IDX_W    = 8,
  parameter int MODE_W   = 2,
  parameter int MODE_RST = 1
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_EVT-1:0] raw_i,
  input  logic [NUM_EVT-1:0] mask_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [DATA_W-1:0]  data_o
);
  always_comb begin
    data_o = '0;
    unique case (addr_i)
      ADDR_W'(AD_INDEX):  data_o = DATA_W'(idx_i);
      ADDR_W'(AD_MASK):   data_o = DATA_W'(mask_i);
      ADDR_W'(AD_RAW):    data_o = DATA_W'(raw_i);
      ADDR_W'(AD_MASKED): data_o = DATA_W'(raw_i & mask_i);
      ADDR_W'(AD_MODE):   data_o = DATA_W'(MODE_W'(MODE_RST));
      default:            data_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int IDX_W    = 8,
  parameter int MODE_W   = 2,
  parameter int MODE_RST = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] hw_evt,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_rvalid,
  input  logic               dbg_req,
  input  logic [ADDR_W-1:0]  dbg_addr,
  output logic [DATA_W-1:0]  dbg_rdata,
  output logic               dbg_rvalid,
  output logic               irq_o
);
  logic                cpu_wr, cpu_rd, idx_rd;
  logic [NUM_EVT-1:0]  set_w, clr_w, ack_w;
  logic [NUM_EVT-1:0]  raw_q, mask_q, masked;
  logic [IDX_W-1:0]    idx;
  logic                any;
  logic [DATA_W-1:0]   cpu_mux, dbg_mux;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:NUM_EVT];

  assign cpu_wr = cpu_req && cpu_we;
  assign cpu_rd = cpu_req && !cpu_we;
  assign idx_rd = cpu_rd && (cpu_addr == ADDR_W'(AD_INDEX));
  assign set_w  = (cpu_wr && cpu_addr == ADDR_W'(AD_SET)) ? cpu_wdata[NUM_EVT-1:0] : '0;
  assign clr_w  = (cpu_wr && cpu_addr == ADDR_W'(AD_CLR)) ? cpu_wdata[NUM_EVT-1:0] : '0;
  assign masked = raw_q & mask_q;

  evt_prio_enc #(.NUM_EVT(NUM_EVT), .IDX_W(IDX_W)) u_enc (
    .vec_i(masked), .idx_o(idx), .any_o(any)
  );

  always_comb begin
    for (int i = 0; i < NUM_EVT; i++)
      ack_w[i] = idx_rd && any && (idx == IDX_W'(i));
  end

  evt_status #(.NUM_EVT(NUM_EVT)) u_status (
    .clk(clk), .rst(rst), .set_i(set_w), .hw_i(hw_evt),
    .clr_i(clr_w), .ack_i(ack_w), .raw_o(raw_q)
  );

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (cpu_wr && cpu_addr == ADDR_W'(AD_MASK))
      mask_q <= cpu_wdata[NUM_EVT-1:0];
  end

  evt_read_mux #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                 .IDX_W(IDX_W), .MODE_W(MODE_W), .MODE_RST(MODE_RST)) u_cpu_mux (
    .addr_i(cpu_addr), .raw_i(raw_q), .mask_i(mask_q), .idx_i(idx), .data_o(cpu_mux)
  );

  evt_read_mux #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                 .IDX_W(IDX_W), .MODE_W(MODE_W), .MODE_RST(MODE_RST)) u_dbg_mux (
    .addr_i(dbg_addr), .raw_i(raw_q), .mask_i(mask_q), .idx_i(idx), .data_o(dbg_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
      dbg_rdata  <= '0;
      dbg_rvalid <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_rd;
      dbg_rvalid <= dbg_req;
      irq_o      <= |masked;
      if (cpu_rd)  cpu_rdata <= cpu_mux;
      if (dbg_req) dbg_rdata <= dbg_mux;
    end
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int NUM_EVT = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int IDX_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_EVT-1:0] hw_evt,
  input logic               cpu_req,
  input logic               cpu_we,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic               dbg_req,
  input logic [NUM_EVT-1:0] raw_q,
  input logic [NUM_EVT-1:0] mask_q,
  input logic               any,
  input logic               irq_o,
  input logic               cpu_rvalid,
  input logic [DATA_W-1:0]  cpu_rdata
);
  AST_IDX_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_we && cpu_addr == '0 && any && hw_evt == '0)
      |=> ($countones(raw_q) == $countones($past(raw_q)) - 1)); // R2

  AST_DBG_NO_SIDE: assert property (@(posedge clk) disable iff (rst)
    (dbg_req && !cpu_req && hw_evt == '0) |=> (raw_q == $past(raw_q))); // R3

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hw_evt != '0) |=> ((raw_q & $past(hw_evt)) == $past(hw_evt))); // R10

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq_o == $past(|(raw_q & mask_q)))); // R9

  AST_IDX_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_we && cpu_addr == '0 && !any)
      |=> (cpu_rvalid && cpu_rdata == DATA_W'(8'hFF))); // R1
endmodule

bind evt_irq_ctrl evt_irq_chk #(
  .NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .hw_evt(hw_evt), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .dbg_req(dbg_req), .raw_q(raw_q), .mask_q(mask_q),
  .any(any), .irq_o(irq_o), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 35;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DBG = 2'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  hw_evt = '0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_rvalid;
  logic        dbg_req = 1'b0;
  logic [3:0]  dbg_addr = '0;
  logic [31:0] dbg_rdata;
  logic        dbg_rvalid;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk(clk), .rst(rst), .hw_evt(hw_evt), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .dbg_req(dbg_req), .dbg_addr(dbg_addr),
    .dbg_rdata(dbg_rdata), .dbg_rvalid(dbg_rvalid), .irq_o(irq_o)
  );

  // {op, addr, data, expected, requirement number}
  localparam logic [77:0] VEC [NV] = '{
    {OP_RD,  4'd2, 32'h0,        32'h0,  8'd11}, // R11 raw after reset
    {OP_RD,  4'd1, 32'h0,        32'h0,  8'd11}, // R11 mask after reset
    {OP_RD,  4'd6, 32'h0,        32'h1,  8'd8},  // R8 mode
    {OP_RD,  4'd0, 32'h0,        32'hFF, 8'd1},  // R1 empty index
    {OP_WR,  4'd4, 32'hA,        32'h0,  8'd5},  // R5 set rx, pwrdn
    {OP_RD,  4'd2, 32'h0,        32'hA,  8'd5},  // R5
    {OP_RD,  4'd3, 32'h0,        32'h0,  8'd4},  // R4 all masked
    {OP_RD,  4'd0, 32'h0,        32'hFF, 8'd1},  // R1 masked events hidden
    {OP_WR,  4'd1, 32'hFFFFFFFF, 32'h0,  8'd7},  // R7
    {OP_RD,  4'd1, 32'h0,        32'hF,  8'd7},  // R7 upper mask bits
    {OP_RD,  4'd3, 32'h0,        32'hA,  8'd4},  // R4
    {OP_DBG, 4'd0, 32'h0,        32'h1,  8'd3},  // R3
    {OP_DBG, 4'd0, 32'h0,        32'h1,  8'd3},  // R3 no advance
    {OP_RD,  4'd2, 32'h0,        32'hA,  8'd3},  // R3 raw intact
    {OP_RD,  4'd0, 32'h0,        32'h1,  8'd1},  // R1
    {OP_RD,  4'd0, 32'h0,        32'h3,  8'd2},  // R2 next
    {OP_RD,  4'd0, 32'h0,        32'hFF, 8'd2},  // R2 drained
    {OP_RD,  4'd2, 32'h0,        32'h0,  8'd2},  // R2
    {OP_WR,  4'd4, 32'hF,        32'h0,  8'd5},  // R5
    {OP_WR,  4'd1, 32'h3,        32'h0,  8'd4},  // R4
    {OP_WR,  4'd5, 32'h4,        32'h0,  8'd6},  // R6 clear masked bit
    {OP_RD,  4'd2, 32'h0,        32'hB,  8'd6},  // R6
    {OP_WR,  4'd4, 32'h0,        32'h0,  8'd11}, // R11
    {OP_WR,  4'd5, 32'h0,        32'h0,  8'd11}, // R11
    {OP_RD,  4'd2, 32'h0,        32'hB,  8'd11}, // R11 zero writes
    {OP_WR,  4'd6, 32'h3,        32'h0,  8'd8},  // R8
    {OP_RD,  4'd6, 32'h0,        32'h1,  8'd8},  // R8 write ignored
    {OP_RD,  4'd0, 32'h0,        32'h0,  8'd1},  // R1 tx first
    {OP_RD,  4'd0, 32'h0,        32'h1,  8'd2},  // R2
    {OP_RD,  4'd0, 32'h0,        32'hFF, 8'd1},  // R1 bit3 masked
    {OP_RD,  4'd2, 32'h0,        32'h8,  8'd2},  // R2 empty read clears nothing
    {OP_WR,  4'd4, 32'hFFFFFFF0, 32'h0,  8'd7},  // R7
    {OP_RD,  4'd2, 32'h0,        32'h8,  8'd7},  // R7 upper set bits ignored
    {OP_RD,  4'd9, 32'h0,        32'h0,  8'd7},  // R7 unmapped
    {OP_DBG, 4'd2, 32'h0,        32'h8,  8'd3}   // R3
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic dbg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    dbg_req = 1'b1; dbg_addr = a;
    @(negedge clk);
    dbg_req = 1'b0;
    d = dbg_rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=timeout exp=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 irq after reset", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  a;
      logic [31:0] wd, ex;
      logic [7:0]  rq;
      {op, a, wd, ex, rq} = VEC[i];
      if (op == OP_WR) cpu_write(a, wd);
      else begin
        if (op == OP_RD) cpu_read(a, d);
        else dbg_read(a, d);
        check($sformatf("R%0d vec%0d", rq, i), d, ex);
      end
    end

    // R9: raw=8 mask=3 -> no interrupt; unmask bit 3 -> interrupt
    check("R9 idle", {31'b0, irq_o}, 32'h0);
    cpu_write(4'd1, 32'h8);
    @(negedge clk);
    check("R9 raised", {31'b0, irq_o}, 32'h1);
    cpu_write(4'd5, 32'h8);
    @(negedge clk);
    check("R9 dropped", {31'b0, irq_o}, 32'h0);

    // R10: clear write and hw pulse on bit 0 together
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 4'd5; cpu_wdata = 32'h1; hw_evt = 4'h1;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0; hw_evt = 4'h0;
    cpu_read(4'd2, d);
    check("R10 set wins", d, 32'h1);
    @(negedge clk);
    hw_evt = 4'h4;
    @(negedge clk);
    hw_evt = 4'h0;
    cpu_read(4'd2, d);
    check("R10 hw pulse", d, 32'h5);

    // R12: valid strobe timing
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 4'd6;
    check("R12 no early valid", {31'b0, cpu_rvalid}, 32'h0);
    @(negedge clk);
    cpu_req = 1'b0;
    check("R12 valid", {31'b0, cpu_rvalid}, 32'h1);
    check("R12 data", cpu_rdata, 32'h1);
    @(negedge clk);
    check("R12 one cycle", {31'b0, cpu_rvalid}, 32'h0);
    dbg_read(4'd2, d);
    check("R12 dbg valid", {31'b0, dbg_rvalid}, 32'h1);

    // R11: reset mid-run
    cpu_write(4'd1, 32'hF);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R11 irq reset", {31'b0, irq_o}, 32'h0);
    cpu_read(4'd2, d);
    check("R11 raw reset", d, 32'h0);
    cpu_read(4'd1, d);
    check("R11 mask reset", d, 32'h0);
    cpu_read(4'd6, d);
    check("R11 mode reset", d, 32'h1);

    done = 1'b1;
    finish_run();
  end
endmodule